// File: doc/BRIEF.md
# TDM Serial Audio Transmitter

This block takes parallel audio samples from a valid/ready stream and sends them, most significant bit first, on a single time-division-multiplexed serial line, together with a frame sync. It runs in the system clock domain. A one-cycle `bit_en` strobe marks each bit period. The bit clock itself is made elsewhere. A single holding register sits between the stream and the serializer. A sample is taken from it at the first bit of every enabled slot.

The framing is set by three separate controls: sync length (one bit or one whole slot), a one-bit-early sync offset, and the sync polarity. Together these cover I2S, left-justified, right-justified and both DSP styles. Data inside a slot can be left- or right-aligned, and the padding can be zeros or a copy of the nearest data bit. A 32-entry slot mask removes individual slots from the frame. Normal mode sends one slot per frame, and network mode sends several. Status outputs mark the last slot of a frame, even-numbered slots, and a sticky underrun.

Configuration is captured into a shadow register by a `cfg_load` pulse, and it is meant to be changed only while `en` is low. The reset contents of this register give a two-slot, 16-bit I2S frame.

Top module: `tdm_tx`

## Requirements
- R1: After reset, the shadow configuration holds these values: 2 slots, slot width 16, data width 16, slot-long sync, early sync, active-low sync, network mode, zero padding, left alignment, and all 32 mask bits set. After reset the outputs are `s_ready`=1, `sdo`=0, `sdo_oe`=0, `fs_out`=1, `last_slot`=0, `even_slot`=0 and `underrun`=0.
- R2: A high `cfg_load` captures every `cfg_*` input at that clock edge. The counts are coded as value minus one: `cfg_slots_m1` (slots-1), `cfg_slot_w_m1` (slot bits-1) and `cfg_data_w_m1` (data bits-1). The sample occupies `s_data[data_w-1:0]`.
- R3: After `en` rises, the first bit period is an idle lead bit with `sdo_oe`=0. After that, every `bit_en` strobe sends one bit, most significant data bit first. Outputs are registered. They change only in the clock after a strobe, or go idle in the clock after `en` is low.
- R4: With `cfg_fs_word`=1, the sync is active for every bit of slot 0. With `cfg_fs_word`=0, it is active for bit 0 of slot 0 only.
- R5: With `cfg_fs_early`=1, the sync pattern moves one bit period earlier. It is therefore active during the last bit of the previous frame, and also during the lead bit.
- R6: `cfg_fs_low`=1 inverts `fs_out`. While the block is idle, `fs_out` sits at its inactive level.
- R7: With `cfg_right`=0, data bits fill the start of the slot. With `cfg_right`=1 and the slot wider than the data, padding comes first and the data ends at the last bit of the slot. When the data is wider than the slot, its top bits are sent.
- R8: With `cfg_pad_zero`=1, padding bits are 0. Otherwise they repeat the data LSB when left-aligned, or the data MSB when right-aligned.
- R9: Mask bit s (`{cfg_mask_hi, cfg_mask_lo}`, with slot 0 at bit 0) enables slot s. A disabled slot drives `sdo`=0 and `sdo_oe`=0, consumes no sample and cannot raise an underrun.
- R10: In network mode a frame holds `cfg_slots_m1`+1 slots. In normal mode (`cfg_network`=0) a frame holds slot 0 only.
- R11: `s_ready` is high exactly when the holding register is empty. An accepted sample is sent in the next enabled slot that starts after the acceptance.
- R12: An enabled slot that starts while the holding register is empty is sent as all zeros with `sdo_oe`=1, and `underrun` is set. `underrun` stays set until an `underrun_clr` pulse. A new underrun in the same cycle wins over the clear.
- R13: `last_slot` is high during the bits of the frame's final slot, and `even_slot` is high during the bits of even-numbered slots (slot 0 counts as even). Both are low in the lead bit and while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low returns the framer to the lead position |
| bit_en | input | 1 | One-cycle strobe per bit period |
| cfg_load | input | 1 | Capture the configuration inputs |
| cfg_slots_m1 | input | $clog2(SLOTS_MAX) | Slots per frame minus one |
| cfg_slot_w_m1 | input | $clog2(WORD_MAX) | Slot width minus one |
| cfg_data_w_m1 | input | $clog2(WORD_MAX) | Data width minus one |
| cfg_fs_word | input | 1 | 1: slot-long sync, 0: one-bit sync |
| cfg_fs_early | input | 1 | Sync one bit period before the frame |
| cfg_fs_low | input | 1 | Active-low sync |
| cfg_right | input | 1 | Right-align data in the slot |
| cfg_pad_zero | input | 1 | Zero padding bits |
| cfg_network | input | 1 | 1: multi-slot frame, 0: single slot |
| cfg_mask_lo | input | SLOTS_MAX/2 | Enable bits of the lower half of the slots |
| cfg_mask_hi | input | SLOTS_MAX/2 | Enable bits of the upper half of the slots |
| s_valid | input | 1 | Sample valid |
| s_data | input | WORD_MAX | Sample, LSB-justified |
| s_ready | output | 1 | Holding register empty |
| underrun_clr | input | 1 | Clear the underrun flag |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Serial data drive enable |
| fs_out | output | 1 | Frame sync |
| last_slot | output | 1 | Final slot of the frame in progress |
| even_slot | output | 1 | Even-numbered slot in progress |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default parameters: a 32-slot mask and 32-bit slots. This lets it run a 20-slot frame that reaches the upper mask half, and full 32-bit slots in which 24-bit data is padded. Seeded random configurations, with up to 8 slots, slot widths from 8 to 32 and data both wider and narrower than the slot, are mixed with directed runs of each framing style. The directed runs also cover masked slots, normal mode, and a starved stream followed by clearing the flag.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef struct packed {
    logic fs_word;
    logic fs_early;
    logic fs_low;
    logic right_al;
    logic pad_zero;
    logic network;
  } tdm_mode_t;

  // Raw (active-high) sync for a frame position.
  function automatic logic fs_rule(logic first_slot, logic first_bit, logic word_len);
    return first_slot && (word_len || first_bit);
  endfunction

endpackage

// File: rtl/tdm_tx_cfg.sv
module tdm_tx_cfg
  import tdm_tx_pkg::*;
#(
  parameter int SLOTS_MAX = 32,
  parameter int WORD_MAX  = 32,
  localparam int SLOT_IW  = $clog2(SLOTS_MAX),
  localparam int BIT_IW   = $clog2(WORD_MAX),
  localparam int HALF     = SLOTS_MAX / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [SLOT_IW-1:0] slots_m1_i,
  input  logic [BIT_IW-1:0]  slot_w_m1_i,
  input  logic [BIT_IW-1:0]  data_w_m1_i,
  input  tdm_mode_t          mode_i,
  input  logic [HALF-1:0]    mask_lo_i,
  input  logic [HALF-1:0]    mask_hi_i,
  output logic [SLOT_IW-1:0] slots_m1,
  output logic [BIT_IW-1:0]  slot_w_m1,
  output logic [BIT_IW-1:0]  data_w_m1,
  output tdm_mode_t          mode,
  output logic [SLOTS_MAX-1:0] mask
);

  localparam int DEF_W = (WORD_MAX >= 16) ? 15 : WORD_MAX - 1;
  localparam tdm_mode_t DEF_MODE = '{fs_word: 1'b1, fs_early: 1'b1, fs_low: 1'b1,
                                     right_al: 1'b0, pad_zero: 1'b1, network: 1'b1};

  logic [HALF-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_m1  <= SLOT_IW'(1);
      slot_w_m1 <= BIT_IW'(DEF_W);
      data_w_m1 <= BIT_IW'(DEF_W);
      mode      <= DEF_MODE;
      lo_q      <= '1;
      hi_q      <= '1;
    end else if (load) begin
      slots_m1  <= slots_m1_i;
      slot_w_m1 <= slot_w_m1_i;
      data_w_m1 <= data_w_m1_i;
      mode      <= mode_i;
      lo_q      <= mask_lo_i;
      hi_q      <= mask_hi_i;
    end
  end

  assign mask = {hi_q, lo_q};

endmodule

// File: rtl/tdm_tx_pos.sv
module tdm_tx_pos #(
  parameter int SLOT_IW = 5,
  parameter int BIT_IW  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               bit_en,
  input  logic               network,
  input  logic [SLOT_IW-1:0] slots_m1,
  input  logic [BIT_IW-1:0]  slot_w_m1,
  output logic               lead,
  output logic [SLOT_IW-1:0] slot,
  output logic [BIT_IW-1:0]  bitc,
  output logic [SLOT_IW-1:0] nxt_slot,
  output logic [BIT_IW-1:0]  nxt_bit,
  output logic               in_last
);

  logic [SLOT_IW-1:0] last_idx;

  assign last_idx = network ? slots_m1 : '0;
  assign in_last  = (slot == last_idx);

  always_comb begin
    if (bitc == slot_w_m1) begin
      nxt_bit  = '0;
      nxt_slot = in_last ? '0 : slot + SLOT_IW'(1);
    end else begin
      nxt_bit  = bitc + BIT_IW'(1);
      nxt_slot = slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lead <= 1'b1;
      slot <= '0;
      bitc <= '0;
    end else if (bit_en) begin
      if (lead) begin
        lead <= 1'b0;
      end else begin
        slot <= nxt_slot;
        bitc <= nxt_bit;
      end
    end
  end

endmodule

// File: rtl/tdm_tx_hold.sv
module tdm_tx_hold #(
  parameter int WORD_MAX = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  input  logic [WORD_MAX-1:0] s_data,
  input  logic                take,
  input  logic                ur_clr,
  output logic                s_ready,
  output logic                full,
  output logic [WORD_MAX-1:0] word,
  output logic                underrun
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= 1'b0;
      word     <= '0;
      underrun <= 1'b0;
    end else begin
      if (take && full) begin
        full <= 1'b0;
      end else if (s_valid && !full) begin
        full <= 1'b1;
        word <= s_data;
      end
      if (take && !full) underrun <= 1'b1;
      else if (ur_clr)   underrun <= 1'b0;
    end
  end

  assign s_ready = !full;

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int SLOTS_MAX = 32,
  parameter int WORD_MAX  = 32,
  localparam int SLOT_IW  = $clog2(SLOTS_MAX),
  localparam int BIT_IW   = $clog2(WORD_MAX),
  localparam int HALF     = SLOTS_MAX / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                bit_en,
  input  logic                cfg_load,
  input  logic [SLOT_IW-1:0]  cfg_slots_m1,
  input  logic [BIT_IW-1:0]   cfg_slot_w_m1,
  input  logic [BIT_IW-1:0]   cfg_data_w_m1,
  input  logic                cfg_fs_word,
  input  logic                cfg_fs_early,
  input  logic                cfg_fs_low,
  input  logic                cfg_right,
  input  logic                cfg_pad_zero,
  input  logic                cfg_network,
  input  logic [HALF-1:0]     cfg_mask_lo,
  input  logic [HALF-1:0]     cfg_mask_hi,
  input  logic                s_valid,
  input  logic [WORD_MAX-1:0] s_data,
  output logic                s_ready,
  input  logic                underrun_clr,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                fs_out,
  output logic                last_slot,
  output logic                even_slot,
  output logic                underrun
);

  localparam int LW = BIT_IW + 1;

  logic [SLOT_IW-1:0]   slots_m1;
  logic [BIT_IW-1:0]    slot_w_m1, data_w_m1;
  tdm_mode_t            mode, mode_in;
  logic [SLOTS_MAX-1:0] mask;

  logic                 lead, in_last;
  logic [SLOT_IW-1:0]   slot, nxt_slot;
  logic [BIT_IW-1:0]    bitc, nxt_bit;

  logic                 hold_full;
  logic [WORD_MAX-1:0]  hold_word, cur_word, word_now;

  logic                 slot_on, step, take;
  logic [LW-1:0]        w_len, d_len, pad_lead, rel, idx_w;
  logic                 in_pad, pad_val, bit_val, fs_now, fs_next, fs_raw;

  assign mode_in = '{fs_word: cfg_fs_word, fs_early: cfg_fs_early, fs_low: cfg_fs_low,
                     right_al: cfg_right, pad_zero: cfg_pad_zero, network: cfg_network};

  tdm_tx_cfg #(.SLOTS_MAX(SLOTS_MAX), .WORD_MAX(WORD_MAX)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .slots_m1_i(cfg_slots_m1), .slot_w_m1_i(cfg_slot_w_m1), .data_w_m1_i(cfg_data_w_m1),
    .mode_i(mode_in), .mask_lo_i(cfg_mask_lo), .mask_hi_i(cfg_mask_hi),
    .slots_m1(slots_m1), .slot_w_m1(slot_w_m1), .data_w_m1(data_w_m1),
    .mode(mode), .mask(mask)
  );

  tdm_tx_pos #(.SLOT_IW(SLOT_IW), .BIT_IW(BIT_IW)) u_pos (
    .clk(clk), .rst(rst), .en(en), .bit_en(bit_en), .network(mode.network),
    .slots_m1(slots_m1), .slot_w_m1(slot_w_m1),
    .lead(lead), .slot(slot), .bitc(bitc), .nxt_slot(nxt_slot), .nxt_bit(nxt_bit),
    .in_last(in_last)
  );

  tdm_tx_hold #(.WORD_MAX(WORD_MAX)) u_hold (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .take(take),
    .ur_clr(underrun_clr), .s_ready(s_ready), .full(hold_full), .word(hold_word),
    .underrun(underrun)
  );

  assign slot_on  = !lead && mask[slot];
  assign step     = en && bit_en;
  assign take     = step && slot_on && (bitc == '0);
  assign word_now = (bitc == '0) ? (hold_full ? hold_word : '0) : cur_word;

  assign w_len = {1'b0, slot_w_m1} + LW'(1);
  assign d_len = {1'b0, data_w_m1} + LW'(1);

  // Bit selection inside the slot: padding region and data index.
  always_comb begin
    pad_lead = (mode.right_al && (w_len > d_len)) ? (w_len - d_len) : '0;
    pad_val  = mode.pad_zero ? 1'b0
             : (mode.right_al ? word_now[data_w_m1] : word_now[0]);
    if (mode.right_al) begin
      in_pad = ({1'b0, bitc} < pad_lead);
      rel    = {1'b0, bitc} - pad_lead;
    end else begin
      in_pad = ({1'b0, bitc} >= d_len);
      rel    = {1'b0, bitc};
    end
    idx_w   = {1'b0, data_w_m1} - rel;
    bit_val = in_pad ? pad_val : word_now[idx_w[BIT_IW-1:0]];
  end

  // Sync from the current position, or from the following one when early.
  assign fs_now  = fs_rule(slot == '0, bitc == '0, mode.fs_word);
  assign fs_next = fs_rule(nxt_slot == '0, nxt_bit == '0, mode.fs_word);
  assign fs_raw  = lead ? mode.fs_early : (mode.fs_early ? fs_next : fs_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_word  <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      fs_out    <= 1'b1;
      last_slot <= 1'b0;
      even_slot <= 1'b0;
    end else if (!en) begin
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      fs_out    <= mode.fs_low;
      last_slot <= 1'b0;
      even_slot <= 1'b0;
    end else if (bit_en) begin
      if (take) cur_word <= hold_full ? hold_word : '0;
      sdo       <= slot_on && bit_val;
      sdo_oe    <= slot_on;
      fs_out    <= fs_raw ^ mode.fs_low;
      last_slot <= !lead && in_last;
      even_slot <= !lead && !slot[0];
    end
  end

endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic bit_en,
  input logic s_valid,
  input logic s_ready,
  input logic underrun_clr,
  input logic sdo,
  input logic sdo_oe,
  input logic fs_out,
  input logic underrun
);

  assert_quiet_when_undriven_R9: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

  assert_hold_outputs_between_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !bit_en) |=> ($stable(sdo) && $stable(sdo_oe) && $stable(fs_out)));

  assert_idle_releases_line_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sdo_oe);

  assert_accept_fills_holder_R11: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  assert_underrun_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (underrun && !underrun_clr) |=> underrun);

endmodule

bind tdm_tx tdm_tx_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .bit_en(bit_en), .s_valid(s_valid),
  .s_ready(s_ready), .underrun_clr(underrun_clr), .sdo(sdo), .sdo_oe(sdo_oe),
  .fs_out(fs_out), .underrun(underrun)
);

// File: tb/tdm_tx_test.sv
module tdm_tx_test;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, bit_en = 1'b0, cfg_load = 1'b0;
  logic [4:0]  c_slots_m1 = 5'd1, c_w_m1 = 5'd15, c_d_m1 = 5'd15;
  logic        c_word = 1'b1, c_early = 1'b1, c_low = 1'b1, c_right = 1'b0;
  logic        c_padz = 1'b1, c_net = 1'b1;
  logic [15:0] c_mlo = 16'hFFFF, c_mhi = 16'hFFFF;
  logic        s_valid = 1'b0, underrun_clr = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, sdo, sdo_oe, fs_out, last_slot, even_slot, underrun;

  tdm_tx uut (
    .clk(clk), .rst(rst), .en(en), .bit_en(bit_en), .cfg_load(cfg_load),
    .cfg_slots_m1(c_slots_m1), .cfg_slot_w_m1(c_w_m1), .cfg_data_w_m1(c_d_m1),
    .cfg_fs_word(c_word), .cfg_fs_early(c_early), .cfg_fs_low(c_low),
    .cfg_right(c_right), .cfg_pad_zero(c_padz), .cfg_network(c_net),
    .cfg_mask_lo(c_mlo), .cfg_mask_hi(c_mhi),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .underrun_clr(underrun_clr), .sdo(sdo), .sdo_oe(sdo_oe), .fs_out(fs_out),
    .last_slot(last_slot), .even_slot(even_slot), .underrun(underrun)
  );

  always #5 clk = ~clk;

  int    checks = 0, fails = 0;
  bit    done = 0;
  string phase = "R1 reset";

  // Reference model state
  bit          m_full = 0, m_ur = 0, m_lead = 1;
  logic [31:0] m_data = '0, m_cur = '0;
  int          m_slot = 0, m_bit = 0;

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL [%s] %s: actual %0h expected %0h", phase, what, got, exp);
    end
  endtask

  function automatic bit fsr(int s, int b, bit word_len);
    return (s == 0) && (word_len || b == 0);
  endfunction

  function automatic bit slot_bit(logic [31:0] w, int b, int sw, int dw, bit right, bit padz);
    int  p;
    bit  padv;
    p    = (right && sw > dw) ? sw - dw : 0;
    padv = padz ? 1'b0 : (right ? w[dw-1] : w[0]);
    if (right) begin
      if (b < p) return padv;
      return w[dw-1-(b-p)];
    end
    if (b < dw) return w[dw-1-b];
    return padv;
  endfunction

  task automatic tick(bit feed, bit clr);
    bit acc, act, e_sdo, e_oe, e_fs, e_last, e_even;
    logic [31:0] d, mk;
    int sw, dw, ns, nb, nsl;
    sw = int'(c_w_m1) + 1;
    dw = int'(c_d_m1) + 1;
    ns = c_net ? int'(c_slots_m1) + 1 : 1;
    mk = {c_mhi, c_mlo};
    @(negedge clk);
    d = $urandom;
    bit_en = 1'b0; s_valid = feed; s_data = d; underrun_clr = clr;
    chk("s_ready R11", 32'(s_ready), 32'(!m_full));
    acc = feed && s_ready;
    @(posedge clk);
    if (acc) begin m_full = 1; m_data = d; end
    if (clr) m_ur = 0;
    @(negedge clk);
    bit_en = 1'b1; s_valid = 1'b0; underrun_clr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
    if (m_lead) begin
      e_sdo = 0; e_oe = 0; e_fs = c_early ^ c_low; e_last = 0; e_even = 0;
      m_lead = 0;
    end else begin
      act = mk[m_slot];
      if (m_bit == 0 && act) begin
        if (m_full) begin m_cur = m_data; m_full = 0; end
        else begin m_cur = '0; m_ur = 1; end
      end
      e_oe  = act;
      e_sdo = act ? slot_bit(m_cur, m_bit, sw, dw, c_right, c_padz) : 1'b0;
      if (m_bit == sw - 1) begin nb = 0; nsl = (m_slot == ns - 1) ? 0 : m_slot + 1; end
      else begin nb = m_bit + 1; nsl = m_slot; end
      e_fs   = (c_early ? fsr(nsl, nb, c_word) : fsr(m_slot, m_bit, c_word)) ^ c_low;
      e_last = (m_slot == ns - 1);
      e_even = (m_slot % 2 == 0);
      m_slot = nsl; m_bit = nb;
    end
    chk("sdo R7/R8", 32'(sdo), 32'(e_sdo));
    chk("sdo_oe R9", 32'(sdo_oe), 32'(e_oe));
    chk("fs_out R4/R5/R6", 32'(fs_out), 32'(e_fs));
    chk("last_slot R13", 32'(last_slot), 32'(e_last));
    chk("even_slot R13", 32'(even_slot), 32'(e_even));
    chk("underrun R12", 32'(underrun), 32'(m_ur));
  endtask

  task automatic setc(int slots, int sw, int dw, bit wl, bit early, bit low,
                      bit right, bit padz, bit net, logic [15:0] lo, logic [15:0] hi);
    c_slots_m1 = 5'(slots - 1); c_w_m1 = 5'(sw - 1); c_d_m1 = 5'(dw - 1);
    c_word = wl; c_early = early; c_low = low; c_right = right;
    c_padz = padz; c_net = net; c_mlo = lo; c_mhi = hi;
  endtask

  task automatic run_cfg(string ph, bit load, int frames, int feed_pct, int clr_pct);
    int n;
    phase = ph;
    @(negedge clk);
    en = 1'b0; cfg_load = load;
    @(negedge clk);
    cfg_load = 1'b0; en = 1'b1;
    m_lead = 1; m_slot = 0; m_bit = 0;
    n = 1 + frames * (c_net ? int'(c_slots_m1) + 1 : 1) * (int'(c_w_m1) + 1);
    for (int i = 0; i < n; i++)
      tick($urandom_range(99) < feed_pct, $urandom_range(99) < clr_pct);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("idle sdo_oe R3", 32'(sdo_oe), 32'd0);
    chk("idle fs level R6", 32'(fs_out), 32'(c_low));
    chk("idle flags R13", 32'({last_slot, even_slot}), 32'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL [watchdog] run did not finish: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of the outputs
    chk("reset s_ready R1", 32'(s_ready), 32'd1);
    chk("reset sdo/sdo_oe R1", 32'({sdo, sdo_oe}), 32'd0);
    chk("reset fs_out R1", 32'(fs_out), 32'd1);
    chk("reset flags R1", 32'({last_slot, even_slot, underrun}), 32'd0);

    // R1, R5: reset configuration (2-slot 16-bit I2S) used without a load
    run_cfg("R1 R5 default I2S", 1'b0, 3, 100, 0);
    // R2, R4, R5: DSP-A (bit sync, early), 4 slots
    setc(4, 16, 16, 0, 1, 0, 0, 1, 1, 16'hFFFF, 16'hFFFF);
    run_cfg("R2 R4 R5 DSP-A", 1'b1, 3, 100, 0);
    // R4, R6: DSP-B with inverted sync
    setc(4, 16, 16, 0, 0, 1, 0, 1, 1, 16'hFFFF, 16'hFFFF);
    run_cfg("R4 R6 DSP-B inverted", 1'b1, 3, 100, 0);
    // R7, R8: left-justified, 24-bit data in 32-bit slots, zero pad
    setc(2, 32, 24, 1, 0, 0, 0, 1, 1, 16'hFFFF, 16'hFFFF);
    run_cfg("R7 R8 left zero-pad", 1'b1, 3, 100, 0);
    // R7, R8: right-justified, 16-bit data in 24-bit slots, MSB repeat pad
    setc(2, 24, 16, 1, 0, 0, 1, 0, 1, 16'hFFFF, 16'hFFFF);
    run_cfg("R7 R8 right MSB-pad", 1'b1, 3, 100, 0);
    // R8: left aligned, LSB repeat pad
    setc(2, 20, 12, 0, 1, 0, 0, 0, 1, 16'hFFFF, 16'hFFFF);
    run_cfg("R8 left LSB-pad", 1'b1, 3, 100, 0);
    // R7: data wider than the slot
    setc(3, 8, 12, 0, 0, 0, 1, 1, 1, 16'hFFFF, 16'hFFFF);
    run_cfg("R7 data wider than slot", 1'b1, 3, 100, 0);
    // R9: slots 1 and 4 masked
    setc(6, 16, 16, 0, 1, 0, 0, 1, 1, 16'h002D, 16'h0000);
    run_cfg("R9 mask low half", 1'b1, 3, 100, 0);
    // R9, R10: 20 slots, upper mask half in use
    setc(20, 4, 4, 0, 0, 0, 0, 1, 1, 16'h00FF, 16'h000A);
    run_cfg("R9 R10 mask upper half", 1'b1, 3, 100, 0);
    // R10: normal mode ignores the slot count
    setc(4, 16, 16, 0, 0, 0, 0, 1, 0, 16'hFFFF, 16'hFFFF);
    run_cfg("R10 normal mode", 1'b1, 4, 100, 0);
    // R12: starved stream, then refill with clear pulses
    setc(2, 8, 8, 0, 1, 0, 0, 1, 1, 16'hFFFF, 16'hFFFF);
    run_cfg("R12 starved", 1'b1, 2, 0, 0);
    run_cfg("R11 R12 refill and clear", 1'b0, 3, 100, 25);

    // Seeded random configurations
    for (int k = 0; k < 8; k++) begin
      int sw, dw;
      sw = $urandom_range(32, 8);
      dw = $urandom_range(32, 4);
      setc($urandom_range(8, 1), sw, dw, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), ($urandom_range(3) != 0),
           16'($urandom), 16'($urandom));
      run_cfg("R2 R3 R11 random", 1'b1, 3, 80, 5);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule